// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Register Front End

This block holds the digital codes for a bank of eight 13-bit converter channels. A host writes one channel at a time over a parallel bus made of a 13-bit data word, a 3-bit channel address and two active-low strobes, select and write. Every channel keeps two registers. The staging register is loaded from the bus. The live register holds the code that the converter actually outputs. Staged codes move to the live registers in fixed pairs of channels under four active-low pair-load inputs. Holding all four of those inputs low refreshes every channel in the same cycle.

Codes are offset binary, and mid-scale (0x1000) stands for zero. An active-low clear input and the asynchronous power-on reset both force every staging and live register to mid-scale. Clear takes priority over every other control. For each channel the block also gives a signed two's-complement view of the live code. The strobes of the parallel bus are level-sensitive. In this model they are sampled on a system clock rather than held in transparent latches, and the clear input is brought into the clock domain through a short synchroniser.

Top module: `dac_bank_regs`

## Requirements
- R1: Once power-on reset is released, every live code reads 0x1000 and every signed view reads 0.
- R2: The address selects the staging register, with bit 0 as the least significant bit. Address 0 selects channel 0 and address 7 selects channel 7. A write changes only the addressed staging register.
- R3: A staging register takes the bus data at a clock edge where select and write are both low. If either strobe is high at that edge, no staging register changes.
- R4: Pair-load bit k serves channels 2k and 2k+1. At an edge where bit k is low, those two live registers take their staging values. While bit k is high, those two live registers hold their values.
- R5: When all four pair-load bits are low at the same edge, all eight live codes update at that edge.
- R6: A write and a load of the same pair at one edge put the new bus data into the live register at that same edge.
- R7: A low level on clear sets every staging and live register to 0x1000. This happens no later than the third clock edge after clear falls. From the first edge at which clear is low until two edges after it is released, writes and loads are ignored. The registers stay at 0x1000 after clear is released.
- R8: Power-on reset forces every staging and live register to 0x1000 at once, without waiting for a clock edge.
- R9: The signed view of each channel equals its live code minus 4096, taken as a 13-bit two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Clear to mid-scale, active low |
| cs_n | input | 1 | Bus select, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| addr | input | 3 | Channel address of the staging register |
| data | input | 13 | Code written to the staging register |
| ld_n | input | 4 | Pair-load inputs, active low; bit k serves channels 2k and 2k+1 |
| out_code | output | 104 | Live codes; channel c occupies bits 13c+12 down to 13c |
| out_signed | output | 104 | Signed views of the live codes, laid out the same way |

## Verification
A write or load sampled at a clock edge appears on the live codes at that edge and not before it, and the signed view follows the live code with no extra register. The bench drives its inputs after the falling edge and checks its model one time unit after the next rising edge. Clear passes through two synchroniser stages and takes effect one edge after them, so the bench holds clear low for five edges and waits three edges after releasing it before it checks. The effect of power-on reset is checked before any clock edge follows it.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
   // mid-scale code (bipolar zero) for a given code width
   function automatic logic [31:0] mid_code(input int unsigned width);
      return 32'd1 << (width - 1);
   endfunction
endpackage

// File: rtl/dac_clr_sync.sv
module dac_clr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_n,
   output logic clr_act
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("dac_clr_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b1;
            else        stage_q <= ~clr_n;
         end
         assign clr_act = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], ~clr_n};
         end
         assign clr_act = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dac_input_bank.sv
module dac_input_bank
   import dac_bank_pkg::*;
#(
   parameter int unsigned CODE_W   = 13,
   parameter int unsigned CHANNELS = 8,
   localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_act,
   input  logic                       wr_go,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [CODE_W-1:0]          data,
   output logic [CHANNELS-1:0]        wr_en,
   output logic [CHANNELS*CODE_W-1:0] stage_next
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         logic [CODE_W-1:0] stage_q;
         assign wr_en[c] = wr_go && (addr == ADDR_W'(c));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stage_q <= MID;
            else if (clr_act)  stage_q <= MID;
            else if (wr_en[c]) stage_q <= data;
         end
         // value the staging register holds after this edge
         assign stage_next[c*CODE_W +: CODE_W] = wr_en[c] ? data : stage_q;
      end
   endgenerate
endmodule

// File: rtl/dac_output_bank.sv
module dac_output_bank
   import dac_bank_pkg::*;
#(
   parameter int unsigned CODE_W      = 13,
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned CH_PER_LOAD = 2,
   localparam int unsigned LOADS      = CHANNELS / CH_PER_LOAD
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_act,
   input  logic [LOADS-1:0]           ld_go,
   input  logic [CHANNELS*CODE_W-1:0] stage_next,
   output logic [CHANNELS*CODE_W-1:0] live_code
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         localparam int unsigned GRP = c / CH_PER_LOAD;
         logic [CODE_W-1:0] live_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          live_q <= MID;
            else if (clr_act)    live_q <= MID;
            else if (ld_go[GRP]) live_q <= stage_next[c*CODE_W +: CODE_W];
         end
         assign live_code[c*CODE_W +: CODE_W] = live_q;
      end
   endgenerate
endmodule

// File: rtl/dac_code_view.sv
module dac_code_view
   import dac_bank_pkg::*;
#(
   parameter int unsigned CODE_W   = 13,
   parameter int unsigned CHANNELS = 8
) (
   input  logic [CHANNELS*CODE_W-1:0] code_in,
   output logic [CHANNELS*CODE_W-1:0] signed_out
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         assign signed_out[c*CODE_W +: CODE_W] = code_in[c*CODE_W +: CODE_W] - MID;
      end
   endgenerate
endmodule

// File: rtl/dac_bank_regs.sv
module dac_bank_regs #(
   parameter int unsigned CODE_W      = 13,
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned CH_PER_LOAD = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = $clog2(CHANNELS),
   localparam int unsigned LOADS      = CHANNELS / CH_PER_LOAD
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr_n,
   input  logic                       cs_n,
   input  logic                       wr_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [CODE_W-1:0]          data,
   input  logic [LOADS-1:0]           ld_n,
   output logic [CHANNELS*CODE_W-1:0] out_code,
   output logic [CHANNELS*CODE_W-1:0] out_signed
);
   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("dac_bank_regs: CODE_W must be at least 2");
      end
      if (CH_PER_LOAD == 0 || (CHANNELS % CH_PER_LOAD) != 0) begin : g_bad_group
         $error("dac_bank_regs: CHANNELS must be a multiple of CH_PER_LOAD");
      end
      if ((1 << ADDR_W) != CHANNELS) begin : g_bad_count
         $error("dac_bank_regs: CHANNELS must be a power of two");
      end
   endgenerate

   logic                       clr_act;
   logic                       blocked;
   logic                       wr_go;
   logic [LOADS-1:0]           ld_go;
   logic [CHANNELS-1:0]        wr_en;
   logic [CHANNELS*CODE_W-1:0] stage_next;

   dac_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_n   (clr_n),
      .clr_act (clr_act)
   );

   // any sign of clear blocks bus writes and pair loads
   assign blocked = clr_act | ~clr_n;
   assign wr_go   = ~cs_n & ~wr_n & ~blocked;
   assign ld_go   = ~ld_n & {LOADS{~blocked}};

   dac_input_bank #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) u_in (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_act    (clr_act),
      .wr_go      (wr_go),
      .addr       (addr),
      .data       (data),
      .wr_en      (wr_en),
      .stage_next (stage_next)
   );

   dac_output_bank #(.CODE_W(CODE_W), .CHANNELS(CHANNELS), .CH_PER_LOAD(CH_PER_LOAD)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_act    (clr_act),
      .ld_go      (ld_go),
      .stage_next (stage_next),
      .live_code  (out_code)
   );

   dac_code_view #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) u_view (
      .code_in    (out_code),
      .signed_out (out_signed)
   );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk
   import dac_bank_pkg::*;
#(
   parameter int unsigned CODE_W      = 13,
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned CH_PER_LOAD = 2,
   localparam int unsigned ADDR_W     = $clog2(CHANNELS),
   localparam int unsigned LOADS      = CHANNELS / CH_PER_LOAD
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       clr_n,
   input logic                       cs_n,
   input logic                       wr_n,
   input logic [ADDR_W-1:0]          addr,
   input logic [CODE_W-1:0]          data,
   input logic [LOADS-1:0]           ld_n,
   input logic [CHANNELS*CODE_W-1:0] out_code,
   input logic [CHANNELS*CODE_W-1:0] out_signed,
   input logic                       clr_act,
   input logic [CHANNELS-1:0]        wr_en
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));
   localparam int unsigned PW = CODE_W * CH_PER_LOAD;

   // R2: at most one staging register is written per edge
   a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   // R7: an active synchronised clear leaves every live code at mid-scale
   a_r7_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
      clr_act |=> (out_code == {CHANNELS{MID}}));

   // R6: write plus load of the same pair lands in the live register at once
   a_r6_through: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !clr_act && !cs_n && !wr_n && !ld_n[addr / CH_PER_LOAD])
      |=> (out_code[$past(addr)*CODE_W +: CODE_W] == $past(data)));

   generate
      for (genvar p = 0; p < LOADS; p++) begin : g_pair
         // R4: a pair whose load input is high keeps its live codes
         a_r4_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_n[p] && !clr_act) |=> $stable(out_code[p*PW +: PW]));
      end
      for (genvar c = 0; c < CHANNELS; c++) begin : g_view
         // R9: signed view plus the offset gives back the live code
         a_r9_signed_view: assert property (@(posedge clk) disable iff (!rst_n)
            CODE_W'(out_signed[c*CODE_W +: CODE_W] + MID) == out_code[c*CODE_W +: CODE_W]);
      end
   endgenerate
endmodule

bind dac_bank_regs dac_bank_chk #(
   .CODE_W(CODE_W), .CHANNELS(CHANNELS), .CH_PER_LOAD(CH_PER_LOAD)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_n      (clr_n),
   .cs_n       (cs_n),
   .wr_n       (wr_n),
   .addr       (addr),
   .data       (data),
   .ld_n       (ld_n),
   .out_code   (out_code),
   .out_signed (out_signed),
   .clr_act    (clr_act),
   .wr_en      (wr_en)
);

// File: tb/tb_dac_bank_regs.sv
`timescale 1ns/1ps
module tb_dac_bank_regs;
   localparam int W  = 13;
   localparam int CH = 8;
   localparam logic [W-1:0] MID = 13'h1000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            clr_n = 1'b1;
   logic            cs_n = 1'b1;
   logic            wr_n = 1'b1;
   logic [2:0]      addr = '0;
   logic [W-1:0]    data = '0;
   logic [3:0]      ld_n = 4'hF;
   logic [CH*W-1:0] out_code;
   logic [CH*W-1:0] out_signed;

   int errors = 0;
   int checks = 0;
   logic [W-1:0] ein  [CH];
   logic [W-1:0] eout [CH];

   always #2 clk = ~clk;

   dac_bank_regs dut (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
      .addr(addr), .data(data), .ld_n(ld_n),
      .out_code(out_code), .out_signed(out_signed)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < CH; c++) begin
         check(req, out_code[c*W +: W], eout[c]);
         check({req, " R9"}, out_signed[c*W +: W], eout[c] - MID);
      end
   endtask

   task automatic model_mid();
      for (int c = 0; c < CH; c++) begin
         ein[c] = MID;
         eout[c] = MID;
      end
   endtask

   // one clock: drive after falling edge, update model at rising edge, settle
   task automatic step(input logic cs, input logic wr, input logic [2:0] a,
                       input logic [W-1:0] d, input logic [3:0] ld);
      @(negedge clk);
      cs_n = cs; wr_n = wr; addr = a; data = d; ld_n = ld;
      @(posedge clk);
      if (!cs && !wr) ein[a] = d;
      for (int c = 0; c < CH; c++) if (!ld[c/2]) eout[c] = ein[c];
      #1;
   endtask

   task automatic idle();
      step(1'b1, 1'b1, 3'd0, '0, 4'hF);
   endtask

   task automatic t_reset();
      model_mid();
      check_all("R1 reset");
   endtask

   task automatic t_addr_walk();
      for (int a = 0; a < CH; a++)
         step(1'b0, 1'b0, 3'(a), 13'(16'h0101 + a * 16'h0111), 4'hF);
      check_all("R4 hold without load");
      step(1'b1, 1'b1, 3'd0, '0, 4'h0);
      check_all("R2 R5 address walk then load all");
   endtask

   task automatic t_pair_each();
      for (int p = 0; p < 4; p++) begin
         for (int a = 0; a < CH; a++)
            step(1'b0, 1'b0, 3'(a), 13'(16'h0A00 + p * 16'h0040 + a), 4'hF);
         step(1'b1, 1'b1, 3'd0, '0, ~(4'b0001 << p));
         check_all("R4 single pair load");
      end
   endtask

   task automatic t_strobes();
      step(1'b1, 1'b0, 3'd3, 13'h1555, 4'hF);
      step(1'b0, 1'b1, 3'd3, 13'h0AAA, 4'hF);
      step(1'b1, 1'b1, 3'd0, '0, 4'h0);
      check_all("R3 strobe high ignored");
   endtask

   task automatic t_through();
      step(1'b0, 1'b0, 3'd5, 13'h1ABC, 4'b1011);
      check("R6 write-through", out_code[5*W +: W], 13'h1ABC);
      check_all("R6 write-through all");
   endtask

   task automatic t_signed();
      step(1'b0, 1'b0, 3'd0, 13'h0000, 4'hF);
      step(1'b0, 1'b0, 3'd1, 13'h1FFF, 4'hF);
      step(1'b0, 1'b0, 3'd2, 13'h1000, 4'hF);
      step(1'b0, 1'b0, 3'd3, 13'h0FFF, 4'hF);
      step(1'b0, 1'b0, 3'd4, 13'h1001, 4'h0);
      check("R9 zero code", out_signed[0 +: W], 13'h1000);
      check("R9 full code", out_signed[W +: W], 13'h0FFF);
      check("R9 mid code", out_signed[2*W +: W], 13'h0000);
      check("R9 below mid", out_signed[3*W +: W], 13'h1FFF);
      check_all("R9 signed sweep");
   endtask

   task automatic t_clear();
      @(negedge clk);
      clr_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0; addr = 3'd2; data = 13'h0ABC; ld_n = 4'h0;
      repeat (5) @(posedge clk);
      #1;
      model_mid();
      check_all("R7 clear during write and load");
      @(negedge clk);
      clr_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1; ld_n = 4'hF;
      repeat (3) @(posedge clk);
      #1;
      check_all("R7 after release");
      step(1'b1, 1'b1, 3'd0, '0, 4'h0);
      check_all("R7 staging cleared");
   endtask

   task automatic t_por();
      step(1'b0, 1'b0, 3'd6, 13'h0123, 4'h0);
      check("R8 pre-reset value", out_code[6*W +: W], 13'h0123);
      @(negedge clk);
      #0.5 rst_n = 1'b0;
      #0.5;
      model_mid();
      check_all("R8 async reset");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) idle();
      step(1'b1, 1'b1, 3'd0, '0, 4'h0);
      check_all("R8 staging reset");
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      model_mid();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (4) idle();
      t_reset();
      t_addr_walk();
      t_pair_each();
      t_strobes();
      t_through();
      t_signed();
      t_clear();
      t_por();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule